// File: doc/BRIEF.md
# Dual-Port PS/2 Register Interface

This block is a memory-mapped register front end for two PS/2 style serial devices: a keyboard on port 0 and a mouse on port 1. Each port has a bank of four byte-wide registers on 8-byte-aligned addresses: a transmit buffer, a receive buffer, a control register and a status register. Each port also has a receive byte queue of its own and an interrupt line of its own.

The block does not serialise anything onto a real clock/data pair. A byte that software writes to a port's transmit buffer is taken as a device command. A built-in responder then places the reply that the emulated device would send, one or two bytes, into that port's receive queue. Software drains the queue through the receive buffer and polls the status register or waits on the port's interrupt.

The interrupt of a port is high while its queue holds data and its receive-interrupt enable is set. Reads are combinational on the cycle `bus_rd` is high. A receive-buffer read removes the byte at the clock edge that ends that cycle.

Top module: `ps2_dual_regif`

## Requirements
- R1: The byte address is decoded as follows. Bits [2:0] are ignored. Bits [4:3] pick the register: 0 transmit, 1 receive, 2 control, 3 status. Bit 5 picks the port: 0 keyboard, 1 mouse.
- R2: A control write stores three flags: the clock-line flag from bit 4, the receive-interrupt enable from bit 3 and the transmit-interrupt enable from bit 2. A control read returns those flags in the same bit positions, with all other bits 0. After reset the receive-interrupt enable is 1 and the other two flags are 0.
- R3: A status read returns the following, with all other bits 0:
  - the clock-line flag in bit 0;
  - a constant 1 in bit 3 (transmitter empty);
  - a 1 in bit 4 when that port's queue is non-empty.
- R4: A receive read returns the oldest queued byte of that port and removes it, so bytes leave in the order they were queued. When the queue is empty, the read returns 0x00 and changes nothing.
- R5: Transmit byte 0xF2 queues 0xAB and then 0x83. Transmit byte 0xFF queues 0xFA and then 0xAA.
- R6: Each of the transmit bytes 0xED, 0xF3, 0xF4, 0xF5, 0xF6, 0xFA and 0xFC queues the single byte 0xFA.
- R7: Each of the transmit bytes 0xF0, 0x00, 0x03, 0x04, 0x14, 0x28 and 0x76 queues the single byte 0x03.
- R8: Any other transmit byte queues nothing.
- R9: A port's interrupt is 1 exactly while its queue is non-empty and its receive-interrupt enable is 1.
- R10: Each queue holds 16 bytes. A byte pushed into a full queue is dropped. If a two-byte reply finds room for only one byte, the first byte is kept and the second is dropped.
- R11: Writes to the receive and status registers have no effect. A transmit read returns 0x00.
- R12: The two ports are independent. A command, read or control write on one port leaves the other port's queue, flags and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (6) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | NPORTS (2) | Per-port receive interrupt, bit 0 keyboard, bit 1 mouse |

## Verification
The assertions check the following on every cycle:
- queue occupancy never goes past its depth;
- a pop from an empty queue leaves it empty;
- a recognised command lands data in an empty queue;
- an unrecognised command leaves the occupancy unchanged;
- the control flags follow the last control write;
- status bit 3 and the zero transmit read hold;
- a raised interrupt always agrees with the status byte.

Only the bench's scenarios can show the exact reply bytes and their order for every command, and the drop of the second reply byte at the full boundary. They also show address aliasing through the ignored low bits, and that the two ports stay isolated while traffic is interleaved.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;

  typedef enum logic [1:0] {
    REG_TX   = 2'd0,
    REG_RX   = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Reply descriptor: how many bytes to queue, then the bytes in order.
  typedef struct packed {
    logic [1:0] cnt;
    logic [7:0] b0;
    logic [7:0] b1;
  } reply_t;

  localparam logic [7:0] RSP_ACK   = 8'hFA;
  localparam logic [7:0] RSP_ODD   = 8'h03;
  localparam logic [7:0] RSP_ID0   = 8'hAB;
  localparam logic [7:0] RSP_ID1   = 8'h83;
  localparam logic [7:0] RSP_BATOK = 8'hAA;

  // Device responder: maps a command byte to the reply it causes.
  function automatic reply_t reply_for(input logic [7:0] cmd);
    reply_t r;
    r = '0;
    unique case (cmd)
      8'hF2: begin r.cnt = 2'd2; r.b0 = RSP_ID0; r.b1 = RSP_ID1;   end
      8'hFF: begin r.cnt = 2'd2; r.b0 = RSP_ACK; r.b1 = RSP_BATOK; end
      8'hED, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFA, 8'hFC: begin
        r.cnt = 2'd1; r.b0 = RSP_ACK;
      end
      8'hF0, 8'h00, 8'h03, 8'h04, 8'h14, 8'h28, 8'h76: begin
        r.cnt = 2'd1; r.b0 = RSP_ODD;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Status byte: bit 4 data pending, bit 3 transmitter empty, bit 0 clock flag.
  function automatic logic [7:0] status_byte(input logic clk_flag, input logic pending);
    return {3'b000, pending, 1'b1, 2'b00, clk_flag};
  endfunction

  // Control readback: bit 4 clock flag, bit 3 rx irq enable, bit 2 tx irq enable.
  function automatic logic [7:0] ctrl_byte(input logic clk_flag, input logic rxen, input logic txen);
    return {3'b000, clk_flag, rxen, txen, 2'b00};
  endfunction

endpackage

// File: rtl/ps2r_fifo.sv
module ps2r_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   push_n,
  input  logic [W-1:0]                 d0,
  input  logic [W-1:0]                 d1,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         has_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] level_q;

  // Named internal events
  logic             pop_ok;
  logic [CNT_W-1:0] after_pop;
  logic             acc0, acc1;

  assign pop_ok    = pop && (level_q != '0);
  assign after_pop = level_q - CNT_W'(pop_ok);
  assign acc0      = (push_n != 2'd0) && (after_pop < DEPTH_C);
  assign acc1      = (push_n == 2'd2) && ((after_pop + CNT_W'(acc0)) < DEPTH_C);

  always_ff @(posedge clk) begin
    if (acc0) mem[wptr_q] <= d0;
    if (acc1) mem[ptr_inc(wptr_q)] <= d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (acc1)      wptr_q <= ptr_inc(ptr_inc(wptr_q));
      else if (acc0) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok)    rptr_q <= ptr_inc(rptr_q);
      level_q <= after_pop + CNT_W'(acc0) + CNT_W'(acc1);
    end
  end

  assign head     = mem[rptr_q];
  assign has_data = (level_q != '0);
  assign level    = level_q;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= DEPTH_C);

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == DEPTH_C && !pop && push_n != 2'd0) |=> level_q == DEPTH_C);

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == '0 && pop && push_n == 2'd0) |=> level_q == '0);

endmodule

// File: rtl/ps2r_responder.sv
module ps2r_responder
  import ps2r_pkg::*;
(
  input  logic [7:0] cmd,
  output reply_t     rsp
);
  assign rsp = reply_for(cmd);
endmodule

// File: rtl/ps2r_port.sv
module ps2r_port
  import ps2r_pkg::*;
#(
  parameter int QDEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_tx,
  input  logic       wr_ctrl,
  input  logic       rd_rx,
  input  logic [7:0] wdata,
  output logic [7:0] rx_byte,
  output logic [7:0] stat_out,
  output logic [7:0] ctrl_out,
  output logic       has_data,
  output logic       irq
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic clk_flag_q, rxen_q, txen_q;
  reply_t            rsp;
  logic [1:0]        push_n;
  logic [7:0]        head;
  logic [CNT_W-1:0]  level;

  ps2r_responder u_resp (
    .cmd (wdata),
    .rsp (rsp)
  );

  assign push_n = wr_tx ? rsp.cnt : 2'd0;

  ps2r_fifo #(.DEPTH(QDEPTH), .W(8)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (push_n),
    .d0       (rsp.b0),
    .d1       (rsp.b1),
    .pop      (rd_rx),
    .head     (head),
    .has_data (has_data),
    .level    (level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_flag_q <= 1'b0;
      rxen_q     <= 1'b1;
      txen_q     <= 1'b0;
    end else if (wr_ctrl) begin
      clk_flag_q <= wdata[4];
      rxen_q     <= wdata[3];
      txen_q     <= wdata[2];
    end
  end

  assign rx_byte  = has_data ? head : 8'h00;
  assign stat_out = status_byte(clk_flag_q, has_data);
  assign ctrl_out = ctrl_byte(clk_flag_q, rxen_q, txen_q);
  assign irq      = rxen_q && has_data;

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (clk_flag_q == $past(wdata[4]) && rxen_q == $past(wdata[3])
                 && txen_q == $past(wdata[2])));

  assert_reply_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && rsp.cnt != 2'd0 && !has_data) |=> has_data);

  assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && rsp.cnt == 2'd0 && !rd_rx) |=> $stable(level));

endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
  import ps2r_pkg::*;
#(
  parameter int NPORTS   = 2,
  parameter int QDEPTH   = 16,
  parameter int ALIGN_SH = 3,
  parameter int ADDR_W   = ALIGN_SH + 2 + $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NPORTS-1:0] irq
);
  localparam int PORT_W  = $clog2(NPORTS);
  localparam int PORT_LO = ALIGN_SH + 2;

  reg_sel_e          sel_reg;
  logic [PORT_W-1:0] sel_port;
  logic              unused_addr_bits;

  assign sel_reg          = reg_sel_e'(bus_addr[ALIGN_SH+1:ALIGN_SH]);
  assign sel_port         = bus_addr[PORT_LO +: PORT_W];
  assign unused_addr_bits = ^bus_addr[ALIGN_SH-1:0];

  logic [7:0]        rx_b   [NPORTS];
  logic [7:0]        stat_b [NPORTS];
  logic [7:0]        ctrl_b [NPORTS];
  logic [NPORTS-1:0] pend;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = (sel_port == PORT_W'(p));

    ps2r_port #(.QDEPTH(QDEPTH)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_tx    (bus_wr && hit && sel_reg == REG_TX),
      .wr_ctrl  (bus_wr && hit && sel_reg == REG_CTRL),
      .rd_rx    (bus_rd && hit && sel_reg == REG_RX),
      .wdata    (bus_wdata),
      .rx_byte  (rx_b[p]),
      .stat_out (stat_b[p]),
      .ctrl_out (ctrl_b[p]),
      .has_data (pend[p]),
      .irq      (irq[p])
    );

    assert_irq_vs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit && sel_reg == REG_STAT && irq[p]) |-> bus_rdata[4]);
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      unique case (sel_reg)
        REG_TX:   bus_rdata = 8'h00;
        REG_RX:   bus_rdata = rx_b[sel_port];
        REG_CTRL: bus_rdata = ctrl_b[sel_port];
        REG_STAT: bus_rdata = stat_b[sel_port];
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  assert_stat_txe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_reg == REG_STAT) |-> bus_rdata[3]);

  assert_tx_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_reg == REG_TX) |-> bus_rdata == 8'h00);

endmodule

// File: tb/ps2_dual_regif_tb.sv
module ps2_dual_regif_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ps2_dual_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Scoreboard: expected bytes per port, pushed by the driver, popped by reads.
  logic [7:0] sb0[$];
  logic [7:0] sb1[$];
  bit m_clk[2];
  bit m_rxen[2];
  bit m_txen[2];

  function automatic int sb_size(int p);
    return (p == 0) ? sb0.size() : sb1.size();
  endfunction

  task automatic sb_push(int p, logic [7:0] b);
    if (sb_size(p) < 16) begin
      if (p == 0) sb0.push_back(b); else sb1.push_back(b);
    end
  endtask

  task automatic sb_reply(int p, logic [7:0] c);
    if (c == 8'hF2) begin sb_push(p, 8'hAB); sb_push(p, 8'h83); end
    else if (c == 8'hFF) begin sb_push(p, 8'hFA); sb_push(p, 8'hAA); end
    else if (c inside {8'hED, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFA, 8'hFC}) sb_push(p, 8'hFA);
    else if (c inside {8'hF0, 8'h00, 8'h03, 8'h04, 8'h14, 8'h28, 8'h76}) sb_push(p, 8'h03);
  endtask

  function automatic logic [5:0] mk(int p, int r, logic [2:0] low);
    return {p[0], r[1:0], low};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(int p, int r, logic [7:0] d, logic [2:0] low = 3'd0);
    @(negedge clk);
    bus_addr = mk(p, r, low); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    if (r == 0) sb_reply(p, d);
    if (r == 2) begin m_clk[p] = d[4]; m_rxen[p] = d[3]; m_txen[p] = d[2]; end
  endtask

  task automatic bus_read(int p, int r, logic [2:0] low, output logic [7:0] got);
    @(negedge clk);
    bus_addr = mk(p, r, low); bus_rd = 1'b1;
    #5 got = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic chk_rx(int p, string req, logic [2:0] low = 3'd0);
    logic [7:0] got, exp;
    exp = 8'h00;
    if (p == 0) begin if (sb0.size() > 0) exp = sb0.pop_front(); end
    else begin if (sb1.size() > 0) exp = sb1.pop_front(); end
    bus_read(p, 1, low, got);
    check(req, got, exp);
  endtask

  task automatic chk_stat(int p, string req);
    logic [7:0] got;
    bus_read(p, 3, 3'd0, got);
    check(req, got, {3'b000, sb_size(p) != 0, 1'b1, 2'b00, m_clk[p]});
  endtask

  task automatic chk_ctrl(int p, string req);
    logic [7:0] got;
    bus_read(p, 2, 3'd0, got);
    check(req, got, {3'b000, m_clk[p], m_rxen[p], m_txen[p], 2'b00});
  endtask

  task automatic chk_irq(int p, string req);
    check(req, {7'b0, irq[p]}, {7'b0, m_rxen[p] && sb_size(p) != 0});
  endtask

  task automatic drain(int p, string req);
    while (sb_size(p) > 0) chk_rx(p, req);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] got;
    m_rxen[0] = 1'b1; m_rxen[1] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Reset state (R2, R3, R9)
    chk_irq(0, "R9 reset irq0");
    chk_irq(1, "R9 reset irq1");
    chk_stat(0, "R3 reset status p0");
    chk_stat(1, "R3 reset status p1");
    chk_ctrl(0, "R2 reset ctrl p0");

    // Control flags (R2, R3)
    bus_write(0, 2, 8'h1C);
    chk_ctrl(0, "R2 ctrl readback");
    chk_stat(0, "R3 clock flag in status");
    chk_ctrl(1, "R12 other port ctrl untouched");

    // Get-ID reply order (R5, R4, R9)
    bus_write(0, 0, 8'hF2);
    chk_irq(0, "R9 irq with data");
    chk_stat(0, "R3 pending bit");
    chk_rx(0, "R5 id byte0");
    chk_rx(0, "R5 id byte1");
    chk_rx(0, "R4 empty read zero");
    chk_stat(0, "R4 empty stays empty");
    chk_irq(0, "R9 irq after drain");

    // Acknowledge set (R6) and odd-reply set (R7)
    foreach (sb0[i]) ; // no-op keeps queue untouched
    for (int k = 0; k < 7; k++) begin
      logic [7:0] a [7] = '{8'hED, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFA, 8'hFC};
      bus_write(0, 0, a[k]);
      chk_rx(0, "R6 ack reply");
      chk_stat(0, "R6 single byte only");
    end
    for (int k = 0; k < 7; k++) begin
      logic [7:0] a [7] = '{8'hF0, 8'h00, 8'h03, 8'h04, 8'h14, 8'h28, 8'h76};
      bus_write(1, 0, a[k]);
      chk_rx(1, "R7 odd reply");
      chk_stat(1, "R7 single byte only");
    end

    // Unknown commands (R8)
    bus_write(0, 0, 8'h55);
    bus_write(0, 0, 8'hEE);
    chk_stat(0, "R8 unknown queues nothing");
    chk_irq(0, "R8 no irq");

    // Port isolation and reset reply (R12, R5)
    bus_write(1, 0, 8'hFF);
    chk_irq(1, "R9 irq1 raised");
    chk_irq(0, "R12 irq0 unaffected");
    chk_stat(0, "R12 port0 queue unaffected");
    chk_rx(1, "R5 reset byte0", 3'd5);  // R1 low address bits ignored
    chk_rx(1, "R5 reset byte1");

    // Interrupt gating (R9)
    bus_write(1, 2, 8'h00);
    bus_write(1, 0, 8'hF4);
    chk_irq(1, "R9 irq masked");
    chk_stat(1, "R9 data pending while masked");
    bus_write(1, 2, 8'h08);
    chk_irq(1, "R9 irq after enable");
    drain(1, "R4 drain p1");
    chk_irq(1, "R9 irq after drain p1");

    // Ignored writes and transmit read (R11)
    bus_write(0, 0, 8'hF4);
    bus_write(0, 1, 8'h77);
    bus_write(0, 3, 8'hFF);
    chk_stat(0, "R11 status write ignored");
    chk_ctrl(0, "R11 ctrl unchanged");
    bus_read(0, 0, 3'd0, got);
    check("R11 tx read zero", got, 8'h00);
    chk_rx(0, "R11 rx write did not enqueue");
    chk_rx(0, "R11 queue empty after");

    // Full queue (R10): 9 id commands give 18 bytes, 16 kept
    for (int k = 0; k < 9; k++) bus_write(0, 0, 8'hF2);
    chk_stat(0, "R10 full status");
    drain(0, "R10 full contents");
    chk_rx(0, "R10 empty after full drain");
    // 15 held, then a two-byte reply keeps only its first byte
    for (int k = 0; k < 15; k++) bus_write(0, 0, 8'hFC);
    bus_write(0, 0, 8'hF2);
    drain(0, "R10 partial reply");
    chk_rx(0, "R10 second byte dropped");

    // Address aliasing (R1): low bits on the control register
    bus_write(1, 2, 8'h10, 3'd7);
    chk_ctrl(1, "R1 aliased ctrl write");
    chk_stat(1, "R1 aliased clock flag");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule